// File: doc/BRIEF.md
# Corrector Setpoint Serial Transmitter

This block sends signed 16-bit corrector current setpoints one way to a power supply over a serial line. A setpoint word comes in with a one-cycle valid strobe. The block wraps the word in a fixed 22-bit frame. The frame has two low start bits, the 16 data bits (sign bit first, most significant bit first), an even parity bit for the upper byte, an even parity bit for the lower byte, and two high stop bits. It then shifts the frame onto a line that rests high between frames.

The bit period is set at run time through a divider input that counts system clocks per bit. For example, 80 clocks per bit gives 1.25 Mbit/s from a 100 MHz clock. There is no receive path, acknowledge or retry.

A word that arrives while a frame is on the line is held and sent after that frame ends. Each newer arrival replaces the held word, so the supply always receives the most recent setpoint.

Top module: `setpoint_line_tx`

## Requirements
- R1: After reset the line output is high and busy is low.
- R2: A frame is 22 bits in this order: two 0 start bits, data bits 15 down to 0, upper-byte parity, lower-byte parity, and two 1 stop bits.
- R3: Parity is even. The upper-byte parity bit equals the XOR of data bits 15..8, and the lower-byte parity bit equals the XOR of data bits 7..0.
- R4: Every bit stays on the line for exactly `bit_div` clocks. A `bit_div` of 0 is treated as 1.
- R5: When the line is idle, the first start bit appears on the line in the cycle right after the clock edge that samples `sp_valid`.
- R6: Busy is high from that edge until the last stop bit ends. After that, with nothing held, busy is low and the line is high.
- R7: A strobe that arrives while a frame is being sent does not disturb that frame. Its word is sent next, after exactly one idle-high clock, and busy stays high through that gap.
- R8: If several strobes arrive during one frame, only the last word is sent next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_div | input | DIV_W | System clocks per line bit |
| sp_word | input | 16 | Signed setpoint to send |
| sp_valid | input | 1 | One-cycle strobe qualifying `sp_word` |
| line_out | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is being sent or a word is held |

## Verification
Two functions can meet in the same window: shifting out a frame, and accepting new setpoints. The bench provokes this by injecting two strobes back to back in the middle of a frame. It judges the result in three ways. The frame in flight must match its own word bit for bit. Exactly one high, busy clock must follow it. Only the second injected word may then appear. Around this, the bench sweeps walking-one, walking-zero, extreme and arithmetic word patterns, and tries several divider values including 0 and 1. It compares every bit against frames computed independently.

// File: rtl/spx_pkg.sv
package spx_pkg;

    localparam int DATA_W    = 16;
    localparam int FRAME_LEN = 22;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    // Packed so that the first bit on the line sits at the top.
    typedef struct packed {
        logic [1:0]        start;
        logic [DATA_W-1:0] data;
        logic              par_hi;
        logic              par_lo;
        logic [1:0]        stop;
    } spx_frame_t;

    function automatic spx_frame_t spx_build(input logic [DATA_W-1:0] w);
        spx_frame_t f;
        f.start  = 2'b00;
        f.data   = w;
        f.par_hi = ^w[DATA_W-1:DATA_W/2];
        f.par_lo = ^w[DATA_W/2-1:0];
        f.stop   = 2'b11;
        return f;
    endfunction

endpackage

// File: rtl/spx_bit_clock.sv
module spx_bit_clock #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             run,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] eff_div;
    logic [DIV_W-1:0] cnt_q;

    assign eff_div = (div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div;
    assign tick    = run && !restart && (cnt_q == eff_div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: ticks are spaced by the divider, so two in a row only when it is 1
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && run && $stable(div)) |=> (!tick || eff_div == 1));

endmodule

// File: rtl/spx_hold.sv
module spx_hold
    import spx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sp_valid,
    input  logic [DATA_W-1:0] sp_word,
    input  logic              tx_active,
    input  logic              launch,
    output logic              held_v,
    output logic [DATA_W-1:0] held_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_v    <= 1'b0;
            held_word <= '0;
        end else if (sp_valid && (tx_active || held_v)) begin
            held_v    <= 1'b1;
            held_word <= sp_word;
        end else if (launch) begin
            held_v    <= 1'b0;
        end
    end

    // R8: the newest arrival during a frame is what is held
    a_r8_newest_held: assert property (@(posedge clk) disable iff (rst)
        (sp_valid && (tx_active || held_v)) |=> (held_v && held_word == $past(sp_word)));

endmodule

// File: rtl/spx_shifter.sv
module spx_shifter
    import spx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic              tick,
    output logic              active,
    output logic              line
);
    logic [FRAME_LEN-1:0] sh_q;
    logic [IDX_W-1:0]     idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            idx_q  <= '0;
            active <= 1'b0;
        end else if (load) begin
            sh_q   <= spx_build(load_word);
            idx_q  <= '0;
            active <= 1'b1;
        end else if (active && tick) begin
            if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
                active <= 1'b0;
            end else begin
                idx_q <= idx_q + 1'b1;
                sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
            end
        end
    end

    assign line = active ? sh_q[FRAME_LEN-1] : 1'b1;

    // R2: a freshly loaded frame opens with two lows and closes with two highs
    a_r2_markers: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (sh_q[21:20] == 2'b00 && sh_q[1:0] == 2'b11));

    // R3: each byte with its parity bit holds an even number of ones
    a_r3_even_parity: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> ((^{sh_q[19:12], sh_q[3]}) == 1'b0 && (^{sh_q[11:4], sh_q[2]}) == 1'b0));

endmodule

// File: rtl/setpoint_line_tx.sv
module setpoint_line_tx
    import spx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic [DATA_W-1:0] sp_word,
    input  logic              sp_valid,
    output logic              line_out,
    output logic              busy
);
    logic              active;
    logic              tick;
    logic              launch;
    logic              held_v;
    logic [DATA_W-1:0] held_word;
    logic [DATA_W-1:0] launch_word;

    assign launch      = !active && (held_v || sp_valid);
    assign launch_word = held_v ? held_word : sp_word;
    assign busy        = active || held_v;

    spx_bit_clock #(.DIV_W(DIV_W)) u_clock (
        .clk     (clk),
        .rst     (rst),
        .div     (bit_div),
        .run     (active),
        .restart (launch),
        .tick    (tick)
    );

    spx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .sp_valid  (sp_valid),
        .sp_word   (sp_word),
        .tx_active (active),
        .launch    (launch),
        .held_v    (held_v),
        .held_word (held_word)
    );

    spx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (launch),
        .load_word (launch_word),
        .tick      (tick),
        .active    (active),
        .line      (line_out)
    );

    // R1: with nothing to do the line rests high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> line_out);

    // R7: a held word is launched the moment it is released
    a_r7_held_launch: assert property (@(posedge clk) disable iff (rst)
        ($fell(held_v) && !$past(sp_valid)) |-> active);

    // R6: busy only drops once the frame has completed
    a_r6_busy_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!active && line_out));

endmodule

// File: tb/test_setpoint_line_tx.sv
module test_setpoint_line_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bit_div = 16'd4;
    logic [15:0] sp_word = '0;
    logic        sp_valid = 1'b0;
    logic        line_out;
    logic        busy;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    setpoint_line_tx #(.DIV_W(16)) i_setpoint_line_tx (
        .clk(clk), .rst(rst), .bit_div(bit_div), .sp_word(sp_word),
        .sp_valid(sp_valid), .line_out(line_out), .busy(busy)
    );

    function automatic logic [21:0] exp_frame(input logic [15:0] w);
        logic [21:0] f;
        for (int i = 0; i < 22; i++) begin
            if (i < 2)        f[21-i] = 1'b0;
            else if (i < 18)  f[21-i] = w[17-i];
            else if (i == 18) f[21-i] = ^w[15:8];
            else if (i == 19) f[21-i] = ^w[7:0];
            else              f[21-i] = 1'b1;
        end
        return f;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at the negedge following the launch edge; samples each bit once per period.
    task automatic capture(input int per, output logic [21:0] got, output logic busy_ok);
        busy_ok = 1'b1;
        for (int i = 0; i < 22; i++) begin
            got[21-i] = line_out;
            if (busy !== 1'b1) busy_ok = 1'b0;
            repeat (per) @(negedge clk);
        end
    endtask

    task automatic send_one(input string req, input logic [15:0] w, input logic [15:0] div);
        logic [21:0] got;
        logic        bok;
        int          per;
        per = (div == 0) ? 1 : int'(div);
        bit_div  = div;
        sp_word  = w;
        sp_valid = 1'b1;
        @(negedge clk);
        sp_valid = 1'b0;
        capture(per, got, bok);
        check({req, " R2 R3 R4 R5 frame"}, {10'd0, got}, {10'd0, exp_frame(w)});
        check({req, " R6 busy in frame"}, {31'd0, bok}, 32'd1);
        check({req, " R6 idle after"}, {30'd0, line_out, busy}, {30'd0, 1'b1, 1'b0});
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [21:0] got;
        logic        bok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset line/busy", {30'd0, line_out, busy}, {30'd0, 1'b1, 1'b0});

        for (int k = 0; k < 16; k++) send_one("R2 walk1", 16'(1 << k), 16'd4);
        for (int k = 0; k < 16; k++) send_one("R3 walk0", ~16'(1 << k), 16'd4);
        send_one("R2 zero", 16'h0000, 16'd4);
        send_one("R2 ones", 16'hFFFF, 16'd4);
        send_one("R2 minneg", 16'h8000, 16'd4);
        send_one("R2 maxpos", 16'h7FFF, 16'd4);
        for (int k = 0; k < 32; k++) send_one("R3 arith", 16'(k * 16'h1357) ^ 16'(k << 9), 16'd4);

        send_one("R4 div1", 16'hA5C3, 16'd1);
        send_one("R4 div0", 16'h3C5A, 16'd0);
        send_one("R4 div3", 16'h1234, 16'd3);
        send_one("R4 div7", 16'hFEDC, 16'd7);
        send_one("R4 div80", 16'h8001, 16'd80);

        // R7/R8: two strobes land while a frame is on the line
        bit_div  = 16'd4;
        sp_word  = 16'hC0DE;
        sp_valid = 1'b1;
        @(negedge clk);
        sp_valid = 1'b0;
        fork
            capture(4, got, bok);
            begin
                repeat (20) @(negedge clk);
                sp_word  = 16'h1111;
                sp_valid = 1'b1;
                @(negedge clk);
                sp_word  = 16'h2B4D;
                @(negedge clk);
                sp_valid = 1'b0;
            end
        join
        check("R7 frame undisturbed", {10'd0, got}, {10'd0, exp_frame(16'hC0DE)});
        check("R7 busy through frame", {31'd0, bok}, 32'd1);
        check("R7 gap high and busy", {30'd0, line_out, busy}, {30'd0, 1'b1, 1'b1});
        @(negedge clk);
        capture(4, got, bok);
        check("R8 newest word sent", {10'd0, got}, {10'd0, exp_frame(16'h2B4D)});
        check("R8 idle after", {30'd0, line_out, busy}, {30'd0, 1'b1, 1'b0});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule